// File: doc/BRIEF.md
# Bit-Sliced Three-Channel Video Lane Link

This block carries three parallel 8-bit video sample streams across a narrow set of serial lanes and recovers them on the far side. On the video clock, a producer offers one three-channel word per cycle. The word passes through a small dual-clock FIFO into the link clock domain. There a transmit state machine spends three consecutive link cycles, called slots, on each word. In every slot, lane k carries bit k of one channel: channel 0 in slot 0, channel 1 in slot 1, channel 2 in slot 2. A separate marker lane is high during slot 0 only, so a receiver can find the group boundary. The link clock must run at least three times faster than the per-channel sample rate, for example about 48 MHz of slots for 16 MHz channels.

The receiver runs in the link clock domain. It registers the lanes and the marker once. It ignores everything until it sees a marker, then gathers three slots and presents the three recovered samples with a one-cycle valid pulse. The samples stay stable until the next complete group. In a normal system the transmit lanes reach the receive pins through off-chip wiring. A test set-up can loop them back on the same device.

The transmit state machine has four states. TX_IDLE goes to TX_SLOT0 when the FIFO holds a word. TX_SLOT0 goes to TX_SLOT1, and TX_SLOT1 goes to TX_SLOT2. TX_SLOT2 goes back to TX_SLOT0 if another word is waiting, and otherwise to TX_IDLE. A word is taken from the FIFO on each move into TX_SLOT0.

The receive state machine has three states. RX_SEEK goes to RX_SLOT1 when a marker arrives. RX_SLOT1 goes to RX_SLOT2 on a slot without a marker. RX_SLOT2 goes to RX_SEEK on a slot without a marker and publishes the group. A marker seen in RX_SLOT1 or RX_SLOT2 restarts the group and moves to RX_SLOT1.

Top module: `tdm_lane_link`

## Requirements
- R1: `in_ready` is low whenever the FIFO already holds FIFO_DEPTH words. A word offered with `in_valid` high while `in_ready` is low is discarded and never appears on the lanes.
- R2: Accepted words leave in acceptance order. Each word occupies three back-to-back link cycles carrying `in_s0`, then `in_s1`, then `in_s2`. In each of those cycles, `lane_data[k]` equals bit k of that channel's sample.
- R3: `lane_mark` is 1 in the slot carrying channel 0 and 0 in the two slots that follow it.
- R4: When no word is waiting, `lane_data` and `lane_mark` are 0. When a word is waiting at the end of a group, the next group's slot 0 follows with no idle cycle between them.
- R5: After link reset, the receiver produces no output pulse from receive-pin activity until a cycle with `rx_lane_mark` high has been sampled.
- R6: `out_valid` is a single-cycle pulse. It rises at the link clock edge after the edge that samples the slot-2 value on the receive pins.
- R7: While `out_valid` is low, `out_s0`, `out_s1` and `out_s2` keep their previous values.
- R8: A marker sampled while a group is only partly gathered discards the partial group and starts a new one with that marker's slot as channel 0.
- R9: While both resets are asserted and after their release, `lane_data`, `lane_mark`, `out_valid` and all `out_s*` are 0 and `in_ready` is 1.
- R10: With the lanes looped back to the receive pins, every accepted word appears once on `out_s0`/`out_s1`/`out_s2`, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vid_clk | input | 1 | Video sample clock |
| vid_rst_n | input | 1 | Active-low asynchronous reset, video domain |
| in_valid | input | 1 | Producer offers a three-channel word |
| in_s0 | input | 8 | Channel 0 sample |
| in_s1 | input | 8 | Channel 1 sample |
| in_s2 | input | 8 | Channel 2 sample |
| in_ready | output | 1 | FIFO can accept a word this cycle |
| link_clk | input | 1 | Slot clock of the serial link |
| link_rst_n | input | 1 | Active-low asynchronous reset, link domain |
| lane_data | output | 8 | Transmit lanes, lane k carries bit k |
| lane_mark | output | 1 | Transmit slot-0 marker lane |
| rx_lane_data | input | 8 | Receive lanes |
| rx_lane_mark | input | 1 | Receive marker lane |
| out_valid | output | 1 | One-cycle pulse: a full group was recovered |
| out_s0 | output | 8 | Recovered channel 0 sample |
| out_s1 | output | 8 | Recovered channel 1 sample |
| out_s2 | output | 8 | Recovered channel 2 sample |

## Verification
The hardest situation to reach is a misaligned marker. A marker in the middle of a group never occurs in a clean loopback, so the realignment paths out of RX_SLOT1 and RX_SLOT2 are unreachable from the transmitter alone. The bench therefore has a manual mode that disconnects the loopback and drives the receive pins directly. In this mode it applies unmarked activity after reset, markers landing in slot 1 and in slot 2, and groups with no gap between them. Separately, the video clock is made faster than one word per three slots, so continuous bursts fill the FIFO and the discarded offers while `in_ready` is low can be shown never to reach the lanes.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int NUM_CH      = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SLOT0 = 2'd1,
        TX_SLOT1 = 2'd2,
        TX_SLOT2 = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_SEEK  = 2'd0,
        RX_SLOT1 = 2'd1,
        RX_SLOT2 = 2'd2
    } rx_state_e;
endpackage

// File: rtl/tdm_ptr_sync.sv
module tdm_ptr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d};
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tdm_async_fifo.sv
module tdm_async_fifo #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 4
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    output logic              full,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              empty
);
    import tdm_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
    logic [PW-1:0] rgray_in_w, wgray_in_r;
    logic [PW-1:0] wbin_nx, rbin_nx;
    logic          wr_en;

    assign wr_en   = wr_req && !full;
    assign wbin_nx = wbin_q + 1'b1;
    assign rbin_nx = rbin_q + 1'b1;

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_en) begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en) begin
            mem[wbin_q[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (rd_en && !empty) begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    tdm_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rgray_q),
        .q     (rgray_in_w)
    );

    tdm_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wgray_q),
        .q     (wgray_in_r)
    );

    assign full  = (wgray_q == {~rgray_in_w[PW-1:PW-2], rgray_in_w[PW-3:0]});
    assign empty = (rgray_q == wgray_in_r);
    assign rdata = mem[rbin_q[AW-1:0]];
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
    parameter int W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_empty,
    input  logic [tdm_pkg::NUM_CH*W-1:0] fifo_word,
    output logic                         fifo_pop,
    output logic [W-1:0]                 lane_data,
    output logic                         lane_mark
);
    import tdm_pkg::*;

    tx_state_e             state_q, state_d;
    logic [NUM_CH*W-1:0]   word_q;

    // State register and the word being sent
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (fifo_pop) begin
                word_q <= fifo_word;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  state_d = fifo_empty ? TX_IDLE : TX_SLOT0;
            TX_SLOT0: state_d = TX_SLOT1;
            TX_SLOT1: state_d = TX_SLOT2;
            TX_SLOT2: state_d = fifo_empty ? TX_IDLE : TX_SLOT0;
            default:  state_d = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        lane_data = '0;
        lane_mark = 1'b0;
        fifo_pop  = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                fifo_pop = !fifo_empty;
            end
            TX_SLOT0: begin
                lane_data = word_q[0*W +: W];
                lane_mark = 1'b1;
            end
            TX_SLOT1: begin
                lane_data = word_q[1*W +: W];
            end
            TX_SLOT2: begin
                lane_data = word_q[2*W +: W];
                fifo_pop  = !fifo_empty;
            end
            default: begin
                lane_data = '0;
            end
        endcase
    end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
    parameter int W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [W-1:0]                 lane_data,
    input  logic                         lane_mark,
    output logic                         out_valid,
    output logic [tdm_pkg::NUM_CH*W-1:0] out_word
);
    import tdm_pkg::*;

    rx_state_e            state_q, state_d;
    logic [W-1:0]         pins_q;
    logic                 mark_q;
    logic [W-1:0]         hold0_q, hold1_q;
    logic [NUM_CH*W-1:0]  word_q;
    logic                 valid_q;

    // Input capture and state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q  <= '0;
            mark_q  <= 1'b0;
            state_q <= RX_SEEK;
        end else begin
            pins_q  <= lane_data;
            mark_q  <= lane_mark;
            state_q <= state_d;
        end
    end

    // Next state: a marker always means slot 0 of a fresh group
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_SEEK:  state_d = mark_q ? RX_SLOT1 : RX_SEEK;
            RX_SLOT1: state_d = mark_q ? RX_SLOT1 : RX_SLOT2;
            RX_SLOT2: state_d = mark_q ? RX_SLOT1 : RX_SEEK;
            default:  state_d = RX_SEEK;
        endcase
    end

    // Outputs: gather slots, publish on the third
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold0_q <= '0;
            hold1_q <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (mark_q) begin
                hold0_q <= pins_q;
            end else begin
                unique case (state_q)
                    RX_SEEK: begin
                        hold1_q <= hold1_q;
                    end
                    RX_SLOT1: begin
                        hold1_q <= pins_q;
                    end
                    RX_SLOT2: begin
                        word_q  <= {pins_q, hold1_q, hold0_q};
                        valid_q <= 1'b1;
                    end
                    default: begin
                        hold1_q <= hold1_q;
                    end
                endcase
            end
        end
    end

    assign out_valid = valid_q;
    assign out_word  = word_q;
endmodule

// File: rtl/tdm_lane_link.sv
module tdm_lane_link #(
    parameter int SAMPLE_W   = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                vid_clk,
    input  logic                vid_rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_s0,
    input  logic [SAMPLE_W-1:0] in_s1,
    input  logic [SAMPLE_W-1:0] in_s2,
    output logic                in_ready,
    input  logic                link_clk,
    input  logic                link_rst_n,
    output logic [SAMPLE_W-1:0] lane_data,
    output logic                lane_mark,
    input  logic [SAMPLE_W-1:0] rx_lane_data,
    input  logic                rx_lane_mark,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_s0,
    output logic [SAMPLE_W-1:0] out_s1,
    output logic [SAMPLE_W-1:0] out_s2
);
    import tdm_pkg::*;

    localparam int WORD_W = NUM_CH * SAMPLE_W;

    logic              fifo_full;
    logic              fifo_empty;
    logic              fifo_pop;
    logic [WORD_W-1:0] fifo_word;
    logic [WORD_W-1:0] out_word;

    tdm_async_fifo #(.DATA_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .wclk   (vid_clk),
        .wrst_n (vid_rst_n),
        .wr_req (in_valid),
        .wdata  ({in_s2, in_s1, in_s0}),
        .full   (fifo_full),
        .rclk   (link_clk),
        .rrst_n (link_rst_n),
        .rd_en  (fifo_pop),
        .rdata  (fifo_word),
        .empty  (fifo_empty)
    );

    assign in_ready = !fifo_full;

    tdm_tx #(.W(SAMPLE_W)) u_tx (
        .clk        (link_clk),
        .rst_n      (link_rst_n),
        .fifo_empty (fifo_empty),
        .fifo_word  (fifo_word),
        .fifo_pop   (fifo_pop),
        .lane_data  (lane_data),
        .lane_mark  (lane_mark)
    );

    tdm_rx #(.W(SAMPLE_W)) u_rx (
        .clk       (link_clk),
        .rst_n     (link_rst_n),
        .lane_data (rx_lane_data),
        .lane_mark (rx_lane_mark),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    assign out_s0 = out_word[0*SAMPLE_W +: SAMPLE_W];
    assign out_s1 = out_word[1*SAMPLE_W +: SAMPLE_W];
    assign out_s2 = out_word[2*SAMPLE_W +: SAMPLE_W];
endmodule

// File: rtl/tdm_lane_link_chk.sv
module tdm_lane_link_chk #(
    parameter int OUT_W = 24
) (
    input logic             link_clk,
    input logic             link_rst_n,
    input logic             lane_mark,
    input logic             rx_lane_mark,
    input logic             fifo_pop,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_word
);
    // R3
    mark_slot0_only_chk: assert property (@(posedge link_clk) disable iff (!link_rst_n)
        lane_mark |=> !lane_mark ##1 !lane_mark);

    // R4
    pop_starts_group_chk: assert property (@(posedge link_clk) disable iff (!link_rst_n)
        fifo_pop |=> lane_mark);

    // R6
    valid_pulse_chk: assert property (@(posedge link_clk) disable iff (!link_rst_n)
        out_valid |=> !out_valid ##1 !out_valid);

    // R7
    out_hold_chk: assert property (@(posedge link_clk) disable iff (!link_rst_n)
        1'b1 |=> (out_valid || $stable(out_word)));

    // R5
    valid_needs_mark_chk: assert property (@(posedge link_clk) disable iff (!link_rst_n)
        out_valid |-> ($past(rx_lane_mark, 4) && !$past(rx_lane_mark, 3) && !$past(rx_lane_mark, 2)));
endmodule

bind tdm_lane_link tdm_lane_link_chk #(.OUT_W(3 * SAMPLE_W)) u_chk (
    .link_clk     (link_clk),
    .link_rst_n   (link_rst_n),
    .lane_mark    (lane_mark),
    .rx_lane_mark (rx_lane_mark),
    .fifo_pop     (fifo_pop),
    .out_valid    (out_valid),
    .out_word     (out_word)
);

// File: tb/tdm_lane_link_bench.sv
module tdm_lane_link_bench;
    localparam int VID_PERIOD  = 10;
    localparam int LINK_PERIOD = 4;

    logic       vid_clk = 0, link_clk = 0;
    logic       vid_rst_n = 0, link_rst_n = 0;
    logic       in_valid = 0;
    logic [7:0] in_s0 = 0, in_s1 = 0, in_s2 = 0;
    logic       in_ready;
    logic [7:0] lane_data, rx_lane_data;
    logic       lane_mark, rx_lane_mark;
    logic       out_valid;
    logic [7:0] out_s0, out_s1, out_s2;

    logic       manual = 0;
    logic       man_mark = 0;
    logic [7:0] man_data = 0;

    assign rx_lane_data = manual ? man_data : lane_data;
    assign rx_lane_mark = manual ? man_mark : lane_mark;

    always #(VID_PERIOD/2)  vid_clk  = ~vid_clk;
    always #(LINK_PERIOD/2) link_clk = ~link_clk;

    tdm_lane_link u_tdm_lane_link (
        .vid_clk(vid_clk), .vid_rst_n(vid_rst_n), .in_valid(in_valid),
        .in_s0(in_s0), .in_s1(in_s1), .in_s2(in_s2), .in_ready(in_ready),
        .link_clk(link_clk), .link_rst_n(link_rst_n),
        .lane_data(lane_data), .lane_mark(lane_mark),
        .rx_lane_data(rx_lane_data), .rx_lane_mark(rx_lane_mark),
        .out_valid(out_valid), .out_s0(out_s0), .out_s1(out_s1), .out_s2(out_s2)
    );

    int vectors = 0, fails = 0;
    int tx_phase = 0;
    int ready_low = 0;
    bit mon_en = 0;
    logic [23:0] tx_q[$];
    logic [23:0] rx_q[$];
    logic [23:0] last_out = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Reference model compared on every link clock
    always @(negedge link_clk) begin
        if (mon_en) begin
            logic [23:0] front;
            logic [23:0] cur;
            front = (tx_q.size() > 0) ? tx_q[0] : 24'h0;
            if (tx_phase == 0) begin
                if (lane_mark) begin
                    // R2 R3: slot 0 carries channel 0 bit-sliced
                    chk(tx_q.size() > 0 && lane_data == front[7:0], "R2", {24'h0, lane_data}, {24'h0, front[7:0]});
                    tx_phase = 1;
                end else begin
                    // R4: idle lanes are zero
                    chk(lane_data == 8'h0, "R4", {24'h0, lane_data}, 32'h0);
                end
            end else begin
                chk(!lane_mark, "R3", {31'h0, lane_mark}, 32'h0);
                chk(lane_data == front[tx_phase*8 +: 8], "R2", {24'h0, lane_data}, {24'h0, front[tx_phase*8 +: 8]});
                if (tx_phase == 2) begin
                    if (tx_q.size() > 0) void'(tx_q.pop_front());
                    tx_phase = 0;
                end else begin
                    tx_phase++;
                end
            end
            cur = {out_s2, out_s1, out_s0};
            if (out_valid) begin
                // R10: recovered in order, exactly once
                chk(rx_q.size() > 0 && cur == (rx_q.size() > 0 ? rx_q[0] : 24'h0), "R10",
                    {8'h0, cur}, {8'h0, (rx_q.size() > 0 ? rx_q[0] : 24'hx)});
                if (rx_q.size() > 0) void'(rx_q.pop_front());
            end else begin
                // R7: held between pulses
                chk(cur == last_out, "R7", {8'h0, cur}, {8'h0, last_out});
            end
            last_out = cur;
        end
    end

    task automatic do_reset();
        mon_en = 0;
        vid_rst_n = 0; link_rst_n = 0;
        in_valid = 0; man_mark = 0; man_data = 0;
        tx_q.delete(); rx_q.delete();
        tx_phase = 0; last_out = '0;
        repeat (3) @(negedge vid_clk);
        // R9: values during reset
        chk(lane_data == 0 && !lane_mark, "R9", {23'h0, lane_mark, lane_data}, 32'h0);
        chk(!out_valid && {out_s2, out_s1, out_s0} == 0, "R9", {7'h0, out_valid, out_s2, out_s1, out_s0}, 32'h0);
        vid_rst_n = 1;
        @(negedge link_clk);
        link_rst_n = 1;
        @(negedge link_clk);
        chk(in_ready, "R9", {31'h0, in_ready}, 32'h1);
        chk(lane_data == 0 && !lane_mark && !out_valid, "R9", {22'h0, out_valid, lane_mark, lane_data}, 32'h0);
        mon_en = 1;
    endtask

    // mode 0: increment, 1: walking ones, 2: random; gap = idle vid cycles between offers
    task automatic send_burst(input int n, input int mode, input int gap);
        for (int i = 0; i < n; i++) begin
            logic [23:0] w;
            @(negedge vid_clk);
            case (mode)
                0: w = {8'(3*i+2), 8'(3*i+1), 8'(3*i)};
                1: w = {8'(1 << ((i+2) % 8)), 8'(1 << ((i+1) % 8)), 8'(1 << (i % 8))};
                default: w = 24'($urandom);
            endcase
            in_valid = 1;
            {in_s2, in_s1, in_s0} = w;
            if (in_ready) begin
                tx_q.push_back(w);
                rx_q.push_back(w);
            end else begin
                ready_low++;   // R1: this offer must vanish
            end
            for (int g = 0; g < gap; g++) begin
                @(negedge vid_clk);
                in_valid = 0;
            end
        end
        @(negedge vid_clk);
        in_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && rx_q.size() > 0; i++) @(negedge link_clk);
        chk(rx_q.size() == 0, "R10", rx_q.size(), 32'h0);
        repeat (10) @(negedge link_clk);
    endtask

    task automatic drive(input bit m, input logic [7:0] d);
        @(negedge link_clk);
        man_mark = m;
        man_data = d;
    endtask

    initial begin
        do_reset();
        // Loopback bursts
        send_burst(40, 0, 0);
        // R1: continuous offers outrun the link, so the FIFO filled
        chk(ready_low > 0, "R1", ready_low, 32'h1);
        drain();
        send_burst(16, 1, 4);
        drain();
        send_burst(30, 2, 0);
        drain();
        send_burst(20, 2, 2);
        drain();

        // Manual drive of the receive pins
        manual = 1;
        do_reset();
        for (int i = 0; i < 6; i++) begin
            drive(0, 8'hA5 + 8'(i));
            chk(!out_valid, "R5", {31'h0, out_valid}, 32'h0);
        end
        repeat (3) begin
            @(negedge link_clk);
            chk(!out_valid, "R5", {31'h0, out_valid}, 32'h0);
        end
        rx_q.push_back(24'h332211);
        drive(1, 8'h11); drive(0, 8'h22); drive(0, 8'h33); drive(0, 8'h00);
        @(negedge link_clk);
        chk(out_valid, "R6", {31'h0, out_valid}, 32'h1);
        @(negedge link_clk);
        chk(!out_valid, "R6", {31'h0, out_valid}, 32'h0);
        // R8: marker lands in slot 1
        rx_q.push_back(24'hC3C2C1);
        drive(1, 8'hB0); drive(1, 8'hC1); drive(0, 8'hC2); drive(0, 8'hC3); drive(0, 8'h00);
        @(negedge link_clk);
        chk(out_valid, "R8", {31'h0, out_valid}, 32'h1);
        // R8: marker lands in slot 2
        rx_q.push_back(24'hE3E2E1);
        drive(1, 8'hD0); drive(0, 8'hD1); drive(1, 8'hE1); drive(0, 8'hE2); drive(0, 8'hE3); drive(0, 8'h00);
        @(negedge link_clk);
        chk(out_valid, "R8", {31'h0, out_valid}, 32'h1);
        // Back-to-back groups
        rx_q.push_back(24'hF3F2F1);
        rx_q.push_back(24'h070605);
        drive(1, 8'hF1); drive(0, 8'hF2); drive(0, 8'hF3);
        drive(1, 8'h05); drive(0, 8'h06); drive(0, 8'h07); drive(0, 8'h00);
        repeat (6) @(negedge link_clk);
        chk(rx_q.size() == 0, "R10", rx_q.size(), 32'h0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge link_clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule